// File: doc/BRIEF.md
# Flash Power Mode Sequencer

This block decides the power state of an on-chip flash/OTP array. The array is always in one of three modes: sleep (lowest power), standby, or active (readable). Software selects a lower-power mode by writing a mode field. A read request from the fetch side returns the array to active without any software action. The wake path is fixed. From sleep it goes through standby, and each of the two steps waits for a programmable number of clock cycles before the next one starts.

The requester holds `acc_req` high and keeps it there until `acc_ready` is seen. `acc_ready` is high only while the array is active, so an access that arrives during low power stalls until the wake sequence ends. It is served in the first cycle of active mode. Software reads the current mode from `stat_mode` and sees whether a wake step is running on `stat_waking`. A mode write that arrives while an access is in flight is parked. It takes effect in the first cycle with `acc_req` low.

Top module: `flash_pwr_seq`

## Requirements
- R1: After reset the mode is active (`stat_mode`=2'b11) and both wait counts hold their maximum value 2^CNT_W-1. With the defaults, a wake from sleep therefore asserts `acc_ready` 513 cycles after the request is first sampled.
- R2: A write with `reg_sel`=0 stores `reg_wdata[1:0]` as the requested mode (2'b00 sleep, 2'b01 standby, 2'b11 active). If `acc_req` is low, a sleep or standby request out of active shows on `stat_mode` in the next cycle.
- R3: A mode write of 2'b10, and any write with `reg_sel`=3, is ignored. The mode does not change and neither wait count changes.
- R4: `acc_ready` is high exactly when the mode is active and no wake step is running.
- R5: When `acc_req` is first sampled high in sleep in cycle c, `stat_mode` shows sleep for SB+2 cycles (c included) and standby for ACT+1 cycles. `acc_ready` rises in cycle c+SB+ACT+3. SB is the sleep-to-standby count (`reg_sel`=1) and ACT is the standby-to-active count (`reg_sel`=2).
- R6: When `acc_req` is first sampled high in standby in cycle c, `acc_ready` rises in cycle c+ACT+2. Standby never moves to active in a single cycle.
- R7: `stat_waking` is high in every cycle of both wait steps and in no other cycle.
- R8: A mode write made while `acc_req` is high does not change the mode while the request stays high. It is applied in the first cycle with `acc_req` low. If several writes are parked, the last one wins.
- R9: A software write of active, made in sleep with no access, runs the same two-step wake. A write of standby, made in sleep, runs only the first step and stops in standby after SB+2 cycles.
- R10: A new wait count is used by the next wake step that starts after the write.
- R11: An access that arrives during a wake that software aimed at standby extends the wake on to active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 mode, 1 sleep-to-standby count, 2 standby-to-active count, 3 unused |
| reg_wdata | input | CNT_W | Write data (mode in bits [1:0]) |
| acc_req | input | 1 | Array read request, held until ready |
| acc_ready | output | 1 | Request may be served this cycle |
| stat_mode | output | 2 | Current mode: 00 sleep, 01 standby, 11 active |
| stat_waking | output | 1 | A wake wait step is running |

## Verification
Mode writes made with no access pending show on `stat_mode` one cycle after the write cycle. A wake requested in cycle c gives `acc_ready` at c+SB+ACT+3 when it starts in sleep and at c+ACT+2 when it starts in standby. The bench counts those cycles explicitly. Each step samples 1 ns after the clock edge, and the counting starts from the cycle in which the request or write is first presented. A cycle model in the bench advances on the same stimulus and compares all three outputs after every edge, so parked writes and random request patterns are checked cycle by cycle.

// File: rtl/fpwr_pkg.sv
// Package: shared encodings for the flash power mode sequencer.
// Assumes a two-step wake path (sleep->standby, standby->active).
package fpwr_pkg;

    // Software-visible mode codes; 2'b10 is reserved and never reported.
    typedef enum logic [1:0] {
        MODE_SLEEP = 2'b00,
        MODE_STBY  = 2'b01,
        MODE_RSVD  = 2'b10,
        MODE_ACT   = 2'b11
    } pwr_mode_e;

    // Internal sequencer states.
    typedef enum logic [2:0] {
        ST_SLEEP    = 3'd0,
        ST_WAKE_SB  = 3'd1,
        ST_STBY     = 3'd2,
        ST_WAKE_ACT = 3'd3,
        ST_ACT      = 3'd4
    } pwr_state_e;

    // Register select codes.
    localparam logic [1:0] SEL_MODE     = 2'd0;
    localparam logic [1:0] SEL_WAIT_SB  = 2'd1;
    localparam logic [1:0] SEL_WAIT_ACT = 2'd2;

    // Number of wake steps, each with its own wait register.
    localparam int N_STAGE = 2;

endpackage

// File: rtl/fpwr_cfg.sv
// Module: fpwr_cfg
// Holds the per-step wake wait counts and parks mode writes that arrive
// while an access is in flight. Assumes acc_req is held until served.
module fpwr_cfg
    import fpwr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           reg_we,
    input  logic [1:0]                     reg_sel,
    input  logic [CNT_W-1:0]               reg_wdata,
    input  logic                           acc_req,
    output logic [N_STAGE-1:0][CNT_W-1:0]  wait_cnt,
    output logic                           apply_vld,
    output pwr_mode_e                      apply_mode
);

    logic      mode_wr;
    logic      pend_q;
    pwr_mode_e pend_mode_q;
    pwr_mode_e wr_mode;

    assign wr_mode = pwr_mode_e'(reg_wdata[1:0]);
    assign mode_wr = reg_we && (reg_sel == SEL_MODE) && (wr_mode != MODE_RSVD);

    // One wait register per wake step, reset to all ones.
    for (genvar g = 0; g < N_STAGE; g++) begin : g_wait
        localparam logic [1:0] MY_SEL = 2'(int'(SEL_WAIT_SB) + g);
        logic [CNT_W-1:0] q;
        // Capture a new count when this step's register is selected.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '1;
            else if (reg_we && (reg_sel == MY_SEL))
                q <= reg_wdata;
        end
        assign wait_cnt[g] = q;
    end

    // Park a mode write made during an access; drop it once applied.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q      <= 1'b0;
            pend_mode_q <= MODE_ACT;
        end else if (mode_wr && acc_req) begin
            pend_q      <= 1'b1;
            pend_mode_q <= wr_mode;
        end else if (!acc_req) begin
            pend_q      <= 1'b0;
        end
    end

    // A fresh write wins over a parked one; nothing applies during an access.
    always_comb begin
        apply_vld  = !acc_req && (mode_wr || pend_q);
        apply_mode = mode_wr ? wr_mode : pend_mode_q;
    end

endmodule

// File: rtl/fpwr_cnt.sv
// Module: fpwr_cnt
// Loadable down-counter for wake wait steps; saturates at zero.
// Assumes the controller loads it on entry to each wait step.
module fpwr_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_q;

    // Load on request, otherwise count down towards zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/fpwr_ctrl.sv
// Module: fpwr_ctrl
// Power state sequencer. Keeps a target mode (software request, or active
// when an access is pending) and walks the states toward it, spending
// count+1 cycles in each wake step. Assumes apply_vld only when !acc_req.
module fpwr_ctrl
    import fpwr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_req,
    input  logic             apply_vld,
    input  pwr_mode_e        apply_mode,
    input  logic             cnt_zero,
    input  logic [CNT_W-1:0] wait_sb,
    input  logic [CNT_W-1:0] wait_act,
    output logic             cnt_load,
    output logic [CNT_W-1:0] cnt_val,
    output pwr_state_e       state
);

    pwr_mode_e  tgt_q, tgt_d;
    pwr_state_e st_q, st_d;

    // Target: software request first, then an access forces active.
    always_comb begin
        if (apply_vld)
            tgt_d = apply_mode;
        else if (acc_req)
            tgt_d = MODE_ACT;
        else
            tgt_d = tgt_q;
    end

    // Next state and counter load toward the target.
    always_comb begin
        st_d     = st_q;
        cnt_load = 1'b0;
        cnt_val  = wait_sb;
        case (st_q)
            ST_SLEEP: begin
                if (tgt_d != MODE_SLEEP) begin
                    st_d     = ST_WAKE_SB;
                    cnt_load = 1'b1;
                end
            end
            ST_WAKE_SB: begin
                if (tgt_d == MODE_SLEEP) begin
                    st_d = ST_SLEEP;
                end else if (cnt_zero) begin
                    if (tgt_d == MODE_ACT) begin
                        st_d     = ST_WAKE_ACT;
                        cnt_load = 1'b1;
                        cnt_val  = wait_act;
                    end else begin
                        st_d = ST_STBY;
                    end
                end
            end
            ST_STBY: begin
                if (tgt_d == MODE_SLEEP) begin
                    st_d = ST_SLEEP;
                end else if (tgt_d == MODE_ACT) begin
                    st_d     = ST_WAKE_ACT;
                    cnt_load = 1'b1;
                    cnt_val  = wait_act;
                end
            end
            ST_WAKE_ACT: begin
                if (tgt_d == MODE_SLEEP)
                    st_d = ST_SLEEP;
                else if (tgt_d == MODE_STBY)
                    st_d = ST_STBY;
                else if (cnt_zero)
                    st_d = ST_ACT;
            end
            ST_ACT: begin
                if (tgt_d == MODE_SLEEP)
                    st_d = ST_SLEEP;
                else if (tgt_d == MODE_STBY)
                    st_d = ST_STBY;
            end
            default: st_d = ST_ACT;
        endcase
    end

    // State and target registers; reset to active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_ACT;
            tgt_q <= MODE_ACT;
        end else begin
            st_q  <= st_d;
            tgt_q <= tgt_d;
        end
    end

    assign state = st_q;

endmodule

// File: rtl/flash_pwr_seq.sv
// Module: flash_pwr_seq (top)
// Flash/OTP power mode sequencer: software-selected low-power modes,
// automatic two-step wake on access, ready/stall toward the requester,
// and mode status. Assumes the requester holds acc_req until acc_ready.
module flash_pwr_seq
    import fpwr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [1:0]       reg_sel,
    input  logic [CNT_W-1:0] reg_wdata,
    input  logic             acc_req,
    output logic             acc_ready,
    output logic [1:0]       stat_mode,
    output logic             stat_waking
);

    logic [N_STAGE-1:0][CNT_W-1:0] wait_cnt;
    logic                          apply_vld;
    pwr_mode_e                     apply_mode;
    logic                          cnt_load;
    logic [CNT_W-1:0]              cnt_val;
    logic                          cnt_zero;
    pwr_state_e                    state;
    pwr_mode_e                     mode_view;

    fpwr_cfg #(.CNT_W(CNT_W)) i_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_sel    (reg_sel),
        .reg_wdata  (reg_wdata),
        .acc_req    (acc_req),
        .wait_cnt   (wait_cnt),
        .apply_vld  (apply_vld),
        .apply_mode (apply_mode)
    );

    fpwr_ctrl #(.CNT_W(CNT_W)) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_req    (acc_req),
        .apply_vld  (apply_vld),
        .apply_mode (apply_mode),
        .cnt_zero   (cnt_zero),
        .wait_sb    (wait_cnt[0]),
        .wait_act   (wait_cnt[1]),
        .cnt_load   (cnt_load),
        .cnt_val    (cnt_val),
        .state      (state)
    );

    fpwr_cnt #(.CNT_W(CNT_W)) i_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .zero     (cnt_zero)
    );

    // Report the mode the array is in; a wake step shows its source mode.
    always_comb begin
        case (state)
            ST_SLEEP, ST_WAKE_SB:  mode_view = MODE_SLEEP;
            ST_STBY, ST_WAKE_ACT:  mode_view = MODE_STBY;
            default:               mode_view = MODE_ACT;
        endcase
    end

    assign stat_mode   = mode_view;
    assign stat_waking = (state == ST_WAKE_SB) || (state == ST_WAKE_ACT);
    assign acc_ready   = (state == ST_ACT);

endmodule

// File: rtl/fpwr_chk.sv
// Module: fpwr_chk
// Port-level protocol checks for flash_pwr_seq, attached with bind.
module fpwr_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_we,
    input logic [1:0]       reg_sel,
    input logic [CNT_W-1:0] reg_wdata,
    input logic             acc_req,
    input logic             acc_ready,
    input logic [1:0]       stat_mode,
    input logic             stat_waking
);

    a_r4_ready_only_active: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ready |-> (stat_mode == 2'b11 && !stat_waking));

    a_r7_waking_not_active: assert property (@(posedge clk) disable iff (!rst_n)
        stat_waking |-> (stat_mode != 2'b11));

    a_r3_no_reserved_mode: assert property (@(posedge clk) disable iff (!rst_n)
        stat_mode != 2'b10);

    a_r5_sleep_via_standby: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_mode == 2'b00) |=> (stat_mode == 2'b00 || stat_mode == 2'b01));

    a_r6_standby_no_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_mode == 2'b01 && !stat_waking) |=> !acc_ready);

    a_r8_hold_during_access: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && acc_ready) |=> acc_ready);

endmodule

bind flash_pwr_seq fpwr_chk #(.CNT_W(CNT_W)) i_fpwr_chk (.*);

// File: tb/test_flash_pwr_seq.sv
module test_flash_pwr_seq;

    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_we = 1'b0;
    logic [1:0]       reg_sel = 2'd0;
    logic [CNT_W-1:0] reg_wdata = '0;
    logic             acc_req = 1'b0;
    logic             acc_ready;
    logic [1:0]       stat_mode;
    logic             stat_waking;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // model state: 0 sleep, 1 wake-to-standby, 2 standby, 3 wake-to-active, 4 active
    int m_st, m_cnt, m_sb, m_act, m_tgt, m_pmode;
    bit m_pend;

    always #2.5 clk = ~clk;

    flash_pwr_seq #(.CNT_W(CNT_W)) i_flash_pwr_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_we      (reg_we),
        .reg_sel     (reg_sel),
        .reg_wdata   (reg_wdata),
        .acc_req     (acc_req),
        .acc_ready   (acc_ready),
        .stat_mode   (stat_mode),
        .stat_waking (stat_waking)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_mode(int st);
        if (st <= 1) return 0;
        if (st <= 3) return 1;
        return 3;
    endfunction

    task automatic model_step();
        bit mw;
        bit ap;
        int am, tg, nst, ncnt;
        mw = reg_we && reg_sel == 2'd0 && reg_wdata[1:0] != 2'b10;
        ap = !acc_req && (mw || m_pend);
        am = mw ? int'(reg_wdata[1:0]) : m_pmode;
        tg = ap ? am : (acc_req ? 3 : m_tgt);
        nst = m_st;
        ncnt = (m_cnt > 0) ? m_cnt - 1 : 0;
        case (m_st)
            0: if (tg != 0) begin nst = 1; ncnt = m_sb; end
            1: if (tg == 0) nst = 0;
               else if (m_cnt == 0) begin
                   if (tg == 3) begin nst = 3; ncnt = m_act; end
                   else nst = 2;
               end
            2: if (tg == 0) nst = 0;
               else if (tg == 3) begin nst = 3; ncnt = m_act; end
            3: if (tg == 0) nst = 0;
               else if (tg == 1) nst = 2;
               else if (m_cnt == 0) nst = 4;
            default: if (tg == 0) nst = 0; else if (tg == 1) nst = 2;
        endcase
        if (mw && acc_req) begin m_pend = 1'b1; m_pmode = int'(reg_wdata[1:0]); end
        else if (!acc_req) m_pend = 1'b0;
        if (reg_we && reg_sel == 2'd1) m_sb = int'(reg_wdata);
        if (reg_we && reg_sel == 2'd2) m_act = int'(reg_wdata);
        m_tgt = tg; m_st = nst; m_cnt = ncnt;
    endtask

    // Advance one clock, then compare all outputs with the model.
    task automatic tick();
        int got, exp;
        model_step();
        @(posedge clk);
        #1;
        got = {29'd0, stat_mode, stat_waking} * 2 + int'(acc_ready);
        exp = (exp_mode(m_st) * 2 + ((m_st == 1 || m_st == 3) ? 1 : 0)) * 2
              + ((m_st == 4) ? 1 : 0);
        chk("R4/R5/R7 model {mode,waking,ready}", got, exp);
    endtask

    task automatic wr(logic [1:0] sel, int data);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = CNT_W'(data);
        tick();
        reg_we = 1'b0;
    endtask

    // Count cycles from the current one until acc_ready; clears a write after its cycle.
    task automatic measure(output int l, output int slp, output int stb, output int wk);
        l = 0; slp = 0; stb = 0; wk = 0;
        while (!acc_ready && l < 2000) begin
            if (stat_mode == 2'b00) slp++;
            if (stat_mode == 2'b01) stb++;
            if (stat_waking) wk++;
            tick();
            reg_we = 1'b0;
            l++;
        end
    endtask

    initial begin
        int l, slp, stb, wk, n;
        void'($urandom(32'd20240917));
        m_st = 4; m_cnt = 0; m_sb = 255; m_act = 255; m_tgt = 3; m_pend = 0; m_pmode = 3;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        chk("R1 reset mode", int'(stat_mode), 3);
        chk("R4 reset ready", int'(acc_ready), 1);
        chk("R7 reset waking", int'(stat_waking), 0);

        wr(2'd0, 0);
        chk("R2 sleep write", int'(stat_mode), 0);
        chk("R4 not ready in sleep", int'(acc_ready), 0);

        acc_req = 1'b1;
        measure(l, slp, stb, wk);
        chk("R1 default wake latency", l, 513);
        chk("R5 sleep cycles default", slp, 257);
        chk("R5 standby cycles default", stb, 256);
        chk("R7 waking cycles default", wk, 512);
        acc_req = 1'b0; tick();

        wr(2'd1, 3); wr(2'd2, 5);
        wr(2'd0, 0);
        acc_req = 1'b1;
        measure(l, slp, stb, wk);
        chk("R10 new waits latency", l, 11);
        chk("R5 sleep cycles", slp, 5);
        chk("R5 standby cycles", stb, 6);
        acc_req = 1'b0; tick();

        wr(2'd0, 1);
        chk("R2 standby write", int'(stat_mode), 1);
        chk("R7 standby idle", int'(stat_waking), 0);
        acc_req = 1'b1;
        measure(l, slp, stb, wk);
        chk("R6 standby latency", l, 7);
        acc_req = 1'b0; tick();

        wr(2'd0, 2);
        chk("R3 reserved code ignored", int'(stat_mode), 3);
        wr(2'd3, 0);
        chk("R3 select 3 ignored", int'(stat_mode), 3);
        wr(2'd0, 0);
        acc_req = 1'b1;
        measure(l, slp, stb, wk);
        chk("R3 waits unchanged", l, 11);

        // acc_req still high and served
        wr(2'd0, 0);
        chk("R8 mode held during access", int'(stat_mode), 3);
        wr(2'd0, 1);
        tick();
        chk("R8 still ready during access", int'(acc_ready), 1);
        acc_req = 1'b0; tick();
        chk("R8 last parked write applied", int'(stat_mode), 1);

        wr(2'd0, 0);
        reg_we = 1'b1; reg_sel = 2'd0; reg_wdata = CNT_W'(3);
        measure(l, slp, stb, wk);
        chk("R9 software wake latency", l, 11);

        wr(2'd0, 0);
        reg_we = 1'b1; reg_sel = 2'd0; reg_wdata = CNT_W'(1);
        n = 0;
        while (!(stat_mode == 2'b01 && !stat_waking) && n < 100) begin
            tick(); reg_we = 1'b0; n++;
        end
        chk("R9 sleep to standby cycles", n, 5);
        repeat (3) tick();
        chk("R9 stays standby", int'(stat_mode), 1);

        wr(2'd0, 0);
        wr(2'd0, 1);
        acc_req = 1'b1;
        measure(l, slp, stb, wk);
        chk("R11 access extends wake", l, 10);
        chk("R11 ends active", int'(stat_mode), 3);
        acc_req = 1'b0; tick();

        for (int i = 0; i < 4000; i++) begin
            reg_we = ($urandom_range(0, 7) == 0);
            reg_sel = 2'($urandom_range(0, 3));
            reg_wdata = CNT_W'($urandom_range(0, 7));
            if (acc_req && acc_ready) acc_req = ($urandom_range(0, 1) == 0);
            else if (!acc_req) acc_req = ($urandom_range(0, 15) == 0);
            tick();
        end
        reg_we = 1'b0; acc_req = 1'b0;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R5 watchdog: actual %0d cycles expected completion earlier", 150000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule